// File: doc/BRIEF.md
# Floating-Point Compare and Exception Status Unit

This unit holds the exception and condition-code fields of a 64-bit floating-point status word. It has two jobs. The first takes the five IEEE exception flags from an arithmetic operation. The unit then either raises a trap, when any flag is enabled, or merges the flags into a sticky accrued field. The second compares two IEEE-754 operands, single or double precision. It writes a 2-bit relation code into one of four condition-code slots. An unordered result can raise an invalid-operation trap.

The status word can also be loaded whole through a write port. Each update lands in one register stage. A trap shows up as a one-cycle pulse in the same cycle as the status update that goes with it.

Top module: `fpsr_cmp_unit`

## Requirements
- R1: After reset the status word reads all zeros and the trap output is low.
- R2: A write loads `wr_data` into the whole status word in the next cycle and raises no trap. When requests arrive together, a write beats a compare, and a compare beats an arithmetic report.
- R3: An arithmetic report replaces the current-exception field, bits [4:0], with `arith_flags`. The flag order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0. When the flags ANDed with the trap-enable field, bits [27:23] in the same order, are nonzero, the unit does three things: it writes trap-type field [16:14] = 3'b001, it pulses `trap_pulse` for one cycle, and it leaves the accrued field unchanged.
- R4: An arithmetic report with no enabled flag ORs the flags into the accrued field, bits [9:5] in the same order. It leaves the trap-type field as it was and keeps `trap_pulse` low.
- R5: A compare writes the relation code into slot `cc_sel` and leaves the other slots unchanged. The codes are equal=00, less=01, greater=10, unordered=11. The slot's low bit is 10, 32, 34 or 36 for `cc_sel` 0, 1, 2 or 3.
- R6: With `dbl`=0 the operands are the low 32 bits of `op_a`/`op_b` in single format, and the upper 32 bits have no effect. With `dbl`=1 the full 64-bit double format is used.
- R7: Ordering follows the real values. +0 and -0 compare equal. Two negative operands order by inverted magnitude. Infinities are ordinary ordered values.
- R8: An operand with an all-ones exponent and a nonzero fraction is a NaN, and the result is unordered. On a quiet compare (`signaling`=0) with the invalid enable (bit 27) clear, the unit sets accrued-invalid (bit 9) only. It raises no trap, and the current-exception field is unchanged.
- R9: An unordered result on a signaling compare, or with bit 27 set, does three things: it sets current-invalid (bit 4), it writes trap type 3'b001, and it pulses `trap_pulse`.
- R10: With no request, the status word holds its value and `trap_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 64 | First compare operand |
| op_b | input | 64 | Second compare operand |
| dbl | input | 1 | 1 = double precision, 0 = single |
| signaling | input | 1 | Compare traps on any unordered result |
| cc_sel | input | 2 | Condition-code slot select |
| cmp_go | input | 1 | Perform a compare this cycle |
| arith_go | input | 1 | Report arithmetic flags this cycle |
| arith_flags | input | 5 | Exception flags from arithmetic |
| wr_en | input | 1 | Load the status word |
| wr_data | input | 64 | Value to load |
| status | output | 64 | Status word |
| trap_pulse | output | 1 | One-cycle trap indication |

## Verification
The compare is tried with a range of operand pairs:
- ordered pairs that differ in sign;
- pairs that are both negative, which catches a missing magnitude inversion;
- signed zeros, which catch a raw bit comparison;
- infinities;
- quiet NaNs and NaNs with a signaling fraction;
- single operands with garbage in the upper half, which exposes a wrong precision select.

Each compare is steered to each of the four slots, after the other slots have been preloaded. This catches a wrong offset or a wide clear. Arithmetic flag sets are applied with the enables cleared and then with a single enable set. This separates the trap path from the accrual path. Simultaneous requests check the priority order.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int SR_W     = 64;
  localparam int FLAG_W   = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = CEXC_LSB + FLAG_W;
  localparam int TEM_LSB  = CEXC_LSB + 23;
  localparam int INV_IDX  = 4;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;
  localparam int CC_BASE  = 10;
  localparam int CC_W     = 2;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  // low bit of condition-code slot: set 0 at the base, others 22/24/26 above
  function automatic int unsigned cc_lsb(input logic [1:0] sel);
    if (sel == 2'd0) return CC_BASE;
    return CC_BASE + 20 + 2 * int'(sel);
  endfunction

  function automatic logic any_enabled(input logic [FLAG_W-1:0] flags,
                                       input logic [FLAG_W-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/fp_field_split.sv
module fp_field_split #(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  logic [W-1:0] v,
  output logic         sign,
  output logic         is_nan,
  output logic         is_zero,
  output logic [W-2:0] mag
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign sign    = v[W-1];
  assign expo    = v[W-2 -: EXP_W];
  assign frac    = v[FRAC_W-1:0];
  assign mag     = v[W-2:0];
  assign is_nan  = (&expo) && (|frac);
  assign is_zero = (mag == '0);
endmodule

// File: rtl/fp_rel_cmp.sv
module fp_rel_cmp
  import fpsr_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic             nan_a,
  input  logic             zero_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  logic             nan_b,
  input  logic             zero_b,
  input  logic [MAG_W-1:0] mag_b,
  output rel_e             rel
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    if (nan_a || nan_b)         rel = REL_UN;
    else if (zero_a && zero_b)  rel = REL_EQ;
    else if (sign_a != sign_b)  rel = sign_a ? REL_LT : REL_GT;
    else if (mag_eq)            rel = REL_EQ;
    else if (mag_lt ^ sign_a)   rel = REL_LT;
    else                        rel = REL_GT;
  end
endmodule

// File: rtl/fsr_next.sv
module fsr_next
  import fpsr_pkg::*;
(
  input  logic [SR_W-1:0]   cur,
  input  logic              wr_en,
  input  logic [SR_W-1:0]   wr_data,
  input  logic              cmp_go,
  input  rel_e              rel,
  input  logic              signaling,
  input  logic [1:0]        cc_sel,
  input  logic              arith_go,
  input  logic [FLAG_W-1:0] flags,
  output logic [SR_W-1:0]   nxt,
  output logic              trap_nxt,
  output logic              arith_hit,
  output logic              cmp_hit
);
  logic [FLAG_W-1:0] tem;
  int unsigned       slot;

  assign tem       = cur[TEM_LSB +: FLAG_W];
  assign slot      = cc_lsb(cc_sel);
  assign arith_hit = any_enabled(flags, tem);
  assign cmp_hit   = (rel == REL_UN) && (signaling || tem[INV_IDX]);

  always_comb begin
    nxt      = cur;
    trap_nxt = 1'b0;
    if (wr_en) begin
      nxt = wr_data;
    end else if (cmp_go) begin
      nxt[slot +: CC_W] = rel;
      if (rel == REL_UN) begin
        if (cmp_hit) begin
          nxt[CEXC_LSB + INV_IDX]   = 1'b1;
          nxt[FTT_LSB +: FTT_W]     = FTT_IEEE;
          trap_nxt                  = 1'b1;
        end else begin
          nxt[AEXC_LSB + INV_IDX]   = 1'b1;
        end
      end
    end else if (arith_go) begin
      nxt[CEXC_LSB +: FLAG_W] = flags;
      if (arith_hit) begin
        nxt[FTT_LSB +: FTT_W] = FTT_IEEE;
        trap_nxt              = 1'b1;
      end else begin
        nxt[AEXC_LSB +: FLAG_W] = cur[AEXC_LSB +: FLAG_W] | flags;
      end
    end
  end
endmodule

// File: rtl/fpsr_cmp_unit.sv
module fpsr_cmp_unit
  import fpsr_pkg::*;
#(
  parameter int DBL_W   = 64,
  parameter int DBL_EXP = 11,
  parameter int SGL_W   = 32,
  parameter int SGL_EXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DBL_W-1:0]  op_a,
  input  logic [DBL_W-1:0]  op_b,
  input  logic              dbl,
  input  logic              signaling,
  input  logic [1:0]        cc_sel,
  input  logic              cmp_go,
  input  logic              arith_go,
  input  logic [FLAG_W-1:0] arith_flags,
  input  logic              wr_en,
  input  logic [SR_W-1:0]   wr_data,
  output logic [SR_W-1:0]   status,
  output logic              trap_pulse
);
  localparam int NOPS    = 2;
  localparam int DMAG_W  = DBL_W - 1;
  localparam int SMAG_W  = SGL_W - 1;

  logic [DBL_W-1:0]  opnd   [NOPS];
  logic              d_sign [NOPS];
  logic              d_nan  [NOPS];
  logic              d_zero [NOPS];
  logic [DMAG_W-1:0] d_mag  [NOPS];
  logic              s_sign [NOPS];
  logic              s_nan  [NOPS];
  logic              s_zero [NOPS];
  logic [SMAG_W-1:0] s_mag  [NOPS];
  logic              p_sign [NOPS];
  logic              p_nan  [NOPS];
  logic              p_zero [NOPS];
  logic [DMAG_W-1:0] p_mag  [NOPS];

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fp_field_split #(.W(DBL_W), .EXP_W(DBL_EXP)) u_dsplit (
      .v(opnd[k]), .sign(d_sign[k]), .is_nan(d_nan[k]),
      .is_zero(d_zero[k]), .mag(d_mag[k])
    );
    fp_field_split #(.W(SGL_W), .EXP_W(SGL_EXP)) u_ssplit (
      .v(opnd[k][SGL_W-1:0]), .sign(s_sign[k]), .is_nan(s_nan[k]),
      .is_zero(s_zero[k]), .mag(s_mag[k])
    );
    assign p_sign[k] = dbl ? d_sign[k] : s_sign[k];
    assign p_nan[k]  = dbl ? d_nan[k]  : s_nan[k];
    assign p_zero[k] = dbl ? d_zero[k] : s_zero[k];
    assign p_mag[k]  = dbl ? d_mag[k]  : DMAG_W'(s_mag[k]);
  end

  rel_e rel;

  fp_rel_cmp #(.MAG_W(DMAG_W)) u_cmp (
    .sign_a(p_sign[0]), .nan_a(p_nan[0]), .zero_a(p_zero[0]), .mag_a(p_mag[0]),
    .sign_b(p_sign[1]), .nan_b(p_nan[1]), .zero_b(p_zero[1]), .mag_b(p_mag[1]),
    .rel(rel)
  );

  logic [SR_W-1:0] status_nxt;
  logic            trap_nxt;
  logic            arith_hit;
  logic            cmp_hit;

  fsr_next u_next (
    .cur(status), .wr_en(wr_en), .wr_data(wr_data),
    .cmp_go(cmp_go), .rel(rel), .signaling(signaling), .cc_sel(cc_sel),
    .arith_go(arith_go), .flags(arith_flags),
    .nxt(status_nxt), .trap_nxt(trap_nxt),
    .arith_hit(arith_hit), .cmp_hit(cmp_hit)
  );

  // named events for the checker
  logic evt_cmp_unord;
  logic evt_arith_only;
  assign evt_cmp_unord  = cmp_go && !wr_en && (rel == REL_UN);
  assign evt_arith_only = arith_go && !wr_en && !cmp_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= '0;
      trap_pulse <= 1'b0;
    end else begin
      status     <= status_nxt;
      trap_pulse <= trap_nxt;
    end
  end
endmodule

// File: rtl/fpsr_cmp_chk.sv
module fpsr_cmp_chk
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SR_W-1:0]   wr_data,
  input logic              cmp_go,
  input logic              arith_go,
  input logic [FLAG_W-1:0] arith_flags,
  input logic              evt_cmp_unord,
  input logic              evt_arith_only,
  input logic [SR_W-1:0]   status,
  input logic              trap_pulse
);
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (status == $past(wr_data)) && !trap_pulse);

  a_r3_trap_sets_type: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> status[FTT_LSB +: FTT_W] == FTT_IEEE);

  a_r3_cexc_from_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_arith_only) |-> status[CEXC_LSB +: FLAG_W] == $past(arith_flags));

  a_r4_accrued_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |->
      ((status[AEXC_LSB +: FLAG_W] & $past(status[AEXC_LSB +: FLAG_W]))
        == $past(status[AEXC_LSB +: FLAG_W])));

  a_r8_ordered_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmp_go) && !$past(wr_en) && !$past(evt_cmp_unord)) |-> !trap_pulse);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en && !cmp_go && !arith_go)) |-> $stable(status) && !trap_pulse);
endmodule

bind fpsr_cmp_unit fpsr_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .cmp_go(cmp_go), .arith_go(arith_go), .arith_flags(arith_flags),
  .evt_cmp_unord(evt_cmp_unord), .evt_arith_only(evt_arith_only),
  .status(status), .trap_pulse(trap_pulse)
);

// File: tb/fpsr_cmp_unit_bench.sv
module fpsr_cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        dbl = 1'b0, signaling = 1'b0;
  logic [1:0]  cc_sel = '0;
  logic        cmp_go = 1'b0, arith_go = 1'b0, wr_en = 1'b0;
  logic [4:0]  arith_flags = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] status;
  logic        trap_pulse;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  fpsr_cmp_unit u_fpsr_cmp_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dbl(dbl),
    .signaling(signaling), .cc_sel(cc_sel), .cmp_go(cmp_go),
    .arith_go(arith_go), .arith_flags(arith_flags), .wr_en(wr_en),
    .wr_data(wr_data), .status(status), .trap_pulse(trap_pulse)
  );

  typedef struct {
    logic [63:0] st;
    logic        trap;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] mdl = '0;

  // bench-side relation: map values onto an unsigned ordered key
  function automatic logic [1:0] m_rel(input logic [63:0] a, input logic [63:0] b,
                                       input logic d);
    logic [64:0] ka, kb;
    logic na, nb;
    logic [62:0] ma, mb;
    if (d) begin
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      ma = a[62:0]; mb = b[62:0];
    end else begin
      na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      ma = {32'd0, a[30:0]}; mb = {32'd0, b[30:0]};
    end
    if (na || nb) return 2'b11;
    ka = (d ? a[63] : a[31]) ? (65'h1 << 63) - ma : (65'h1 << 63) + ma;
    kb = (d ? b[63] : b[31]) ? (65'h1 << 63) - mb : (65'h1 << 63) + mb;
    if (ka == kb) return 2'b00;
    return (ka < kb) ? 2'b01 : 2'b10;
  endfunction

  function automatic int m_slot(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 32;
      2'd2: return 34;
      default: return 36;
    endcase
  endfunction

  task automatic push(input logic t, input string tag);
    exp_t e;
    e.st = mdl; e.trap = t; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic clear_in();
    cmp_go = 0; arith_go = 0; wr_en = 0;
  endtask

  task automatic do_write(input logic [63:0] d, input string tag);
    @(negedge clk); clear_in();
    wr_en = 1; wr_data = d;
    mdl = d;
    push(1'b0, tag);
  endtask

  task automatic do_arith(input logic [4:0] f, input string tag);
    logic t;
    @(negedge clk); clear_in();
    arith_go = 1; arith_flags = f;
    t = |(f & mdl[27:23]);
    mdl[4:0] = f;
    if (t) mdl[16:14] = 3'b001;
    else   mdl[9:5] = mdl[9:5] | f;
    push(t, tag);
  endtask

  task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic d,
                        input logic sg, input logic [1:0] s, input string tag);
    logic [1:0] r;
    logic t;
    @(negedge clk); clear_in();
    cmp_go = 1; op_a = a; op_b = b; dbl = d; signaling = sg; cc_sel = s;
    r = m_rel(a, b, d);
    t = 1'b0;
    mdl[m_slot(s) +: 2] = r;
    if (r == 2'b11) begin
      if (sg || mdl[27]) begin
        mdl[4] = 1'b1; mdl[16:14] = 3'b001; t = 1'b1;
      end else begin
        mdl[9] = 1'b1;
      end
    end
    push(t, tag);
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk); clear_in();
    push(1'b0, tag);
  endtask

  // monitor: compare each result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (status !== e.st || trap_pulse !== e.trap) begin
          bad++;
          $display("FAIL %s: status=%h trap=%b expected status=%h trap=%b",
                   e.tag, status, trap_pulse, e.st, e.trap);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (status !== 64'd0 || trap_pulse !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: status=%h trap=%b expected 0/0", status, trap_pulse);
    end
    @(negedge clk); rst_n = 1;

    // R2 write, R10 idle
    do_write(64'h0000_003F_0000_0C00, "R2 write");
    do_idle("R10 idle hold");
    do_write(64'h0, "R2 write zero");

    // R3/R4 arithmetic with no enables, then one enable
    do_arith(5'b00001, "R4 accrue inexact");
    do_arith(5'b10100, "R4 accrue inv+unf");
    do_write(64'd1 << 26, "R2 enable overflow");
    do_arith(5'b01000, "R3 overflow trap");
    do_idle("R10 trap one cycle");
    do_arith(5'b00001, "R4 masked inexact");

    // R5/R7 single compares into each slot
    do_write(64'h0000_003F_0000_0C00, "R2 preload slots");
    do_cmp(64'h3F800000, 64'h40000000, 0, 0, 2'd0, "R5 slot0 less");
    do_cmp(64'h40000000, 64'h3F800000, 0, 0, 2'd1, "R5 slot1 greater");
    do_cmp(64'hBF800000, 64'hC0000000, 0, 0, 2'd2, "R7 neg inversion");
    do_cmp(64'hC0000000, 64'hBF800000, 0, 0, 2'd3, "R7 neg less");
    do_cmp(64'h00000000, 64'h80000000, 0, 0, 2'd3, "R7 signed zeros");
    do_cmp(64'h7F800000, 64'h3F800000, 0, 0, 2'd0, "R7 infinity");
    do_cmp(64'h80000000, 64'hBF800000, 0, 0, 2'd1, "R7 neg zero vs neg");

    // R6 precision
    do_cmp(64'h3FF0_0000_0000_0000, 64'hC008_0000_0000_0000, 1, 0, 2'd0, "R6 double gt");
    do_cmp(64'hDEADBEEF_3F800000, 64'h12345678_3F800000, 0, 0, 2'd2, "R6 upper ignored");
    do_cmp(64'h4000_0000_0000_0000, 64'h4000_0000_0000_0001, 1, 0, 2'd1, "R6 double lsb");

    // R8 quiet unordered, R9 trapping unordered
    do_cmp(64'h7FC00000, 64'h3F800000, 0, 0, 2'd0, "R8 quiet nan");
    do_cmp(64'h3F800000, 64'h7FF8_0000_0000_0000, 1, 0, 2'd2, "R8 double nan");
    do_cmp(64'h7F800001, 64'h7F800001, 0, 1, 2'd1, "R9 signaling nan");
    do_write(64'd1 << 27, "R2 enable invalid");
    do_cmp(64'h7FC00000, 64'h0, 0, 0, 2'd3, "R9 invalid enabled");
    do_cmp(64'hFF800000, 64'h7F800000, 0, 1, 2'd0, "R9 signaling ordered");

    // R2 priority
    @(negedge clk); clear_in();
    wr_en = 1; wr_data = 64'h0123; cmp_go = 1; arith_go = 1;
    op_a = 64'h7FC00000; op_b = 0; dbl = 0; signaling = 1; arith_flags = 5'b11111;
    mdl = 64'h0123; push(1'b0, "R2 write beats all");
    do_write(64'h0, "R2 clear");
    @(negedge clk); clear_in();
    cmp_go = 1; arith_go = 1; arith_flags = 5'b11111;
    op_a = 64'h3F800000; op_b = 64'h40000000; dbl = 0; signaling = 0; cc_sel = 2'd1;
    mdl[33:32] = 2'b01; push(1'b0, "R2 cmp beats arith");

    do_idle("R10 idle end");
    do_idle("R10 idle end2");
    @(negedge clk); clear_in();
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule